// File: doc/BRIEF.md
# Glitch-free dual clock post-divider

This block is the output divider stage of a clock generator, in a form that can be synthesized. It has two channels, A and B. Each channel takes one of four frequency sources and divides it by a programmable integer from 1 to 127. The sources are the reference and three synthesizer outputs. All four arrive as single-cycle enable strobes in one system clock domain, so a "source cycle" here means one strobe. Each channel's output is a level that goes high and low at the divided rate.

Each channel keeps two divisor registers, bank 0 and bank 1. A 3-bit select input indexes a programmable 8-entry map, and that map names one bank. Both channels always use the bank the map names. A channel picks up a new divisor, source or bank only at the end of a complete output period. This means a divisor change caused by the select input, or by a register write, never cuts a high or low phase short.

The register file is written through a simple write port. Writes take effect when each channel's current period ends.

Top module: `clk_postdiv_pair`

## Requirements
- R1: After reset all registers read as zero and both outputs are low. Each output stays low until a nonzero divisor is programmed for its channel.
- R2: Address 4 selects the source of each channel. Data bits [1:0] set the source for A and bits [3:2] set the source for B. Code 0 is the reference strobe (src_en bit 0). Codes 1 to 3 are synthesizer strobes (src_en bits 1 to 3). A channel's counter advances only on its selected strobe.
- R3: Divisor registers sit at address 0 (A bank 0), address 1 (A bank 1), address 2 (B bank 0) and address 3 (B bank 1). Each takes wr_data[6:0].
- R4: Address 5 holds the map. Bit i of the map gives the bank (0 or 1) used by both channels while sel equals i.
- R5: With divisor N, the output period is N strobes. The output is high for (N+1)/2 strobes, rounded down, and low for the rest. Even N therefore gives exactly 50% duty.
- R6: A channel loads a new divisor, source and bank only when its period wraps, that is, on the strobe that ends a full period. Between loads, the output changes only on a selected strobe.
- R7: A divisor of 0 holds the output low. While the divisor is 0, the channel reloads its settings on every clock.
- R8: Writes to addresses 6 to 15 change nothing.
- R9: A divisor of 1 keeps the output high for as long as that divisor is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 4 | Source strobes: bit 0 is the reference, bits 1 to 3 are the synthesizers |
| sel | input | 3 | Frequency select that indexes the bank map |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| out_a | output | 1 | Divided output of channel A |
| out_b | output | 1 | Divided output of channel B |

## Verification
A wrong active divisor, source or counter value in a channel shows up at out_a or out_b no later than the next selected strobe. The high or low phase then has a different length than the reference model predicts, so a per-clock comparison catches it within one output period. A load that happens mid-period shortens a phase at once. A wrong map bit or crosspoint code shows up after the next wrap.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;

  localparam int N_SRC_DEF  = 4;
  localparam int DIV_W_DEF  = 7;
  localparam int SEL_W_DEF  = 3;
  localparam int ADDR_W_DEF = 4;
  localparam int DATA_W_DEF = 8;

  // Number of strobes the output spends high for a divisor n.
  function automatic int high_len(input int n);
    return (n + 1) / 2;
  endfunction

  // Last counter value of a period with divisor n (n >= 1).
  function automatic int last_count(input int n);
    return n - 1;
  endfunction

endpackage

// File: rtl/postdiv_regs.sv
module postdiv_regs
  import postdiv_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int N_SRC  = N_SRC_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int SEL_W  = SEL_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int MAP_N = 1 << SEL_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [SEL_W-1:0]             sel,
  output logic [N_CH-1:0][DIV_W-1:0]   nxt_div,
  output logic [N_CH-1:0][SRC_W-1:0]   nxt_src,
  output logic                         bank
);

  localparam int XBAR_ADDR = 2 * N_CH;
  localparam int MAP_ADDR  = XBAR_ADDR + 1;

  logic [N_CH*SRC_W-1:0] xbar_q;
  logic [MAP_N-1:0]      map_q;
  logic                  wr_xbar;
  logic                  wr_map;

  assign wr_xbar = wr_en && (wr_addr == ADDR_W'(XBAR_ADDR));
  assign wr_map  = wr_en && (wr_addr == ADDR_W'(MAP_ADDR));

  // One shared bank choice for every channel.
  assign bank = map_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbar_q <= '0;
      map_q  <= '0;
    end else begin
      if (wr_xbar) xbar_q <= wr_data[N_CH*SRC_W-1:0];
      if (wr_map)  map_q  <= wr_data[MAP_N-1:0];
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [DIV_W-1:0] div0_q;
    logic [DIV_W-1:0] div1_q;
    logic             wr0;
    logic             wr1;

    assign wr0 = wr_en && (wr_addr == ADDR_W'(2 * ch));
    assign wr1 = wr_en && (wr_addr == ADDR_W'(2 * ch + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div0_q <= '0;
        div1_q <= '0;
      end else begin
        if (wr0) div0_q <= wr_data[DIV_W-1:0];
        if (wr1) div1_q <= wr_data[DIV_W-1:0];
      end
    end

    assign nxt_div[ch] = bank ? div1_q : div0_q;
    assign nxt_src[ch] = xbar_q[ch*SRC_W +: SRC_W];
  end

endmodule

// File: rtl/postdiv_channel.sv
module postdiv_channel
  import postdiv_pkg::*;
#(
  parameter int N_SRC  = N_SRC_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_en,
  input  logic [DIV_W-1:0]  nxt_div,
  input  logic [SRC_W-1:0]  nxt_src,
  output logic              clk_out,
  output logic              wrap
);

  logic [DIV_W-1:0] act_div;
  logic [SRC_W-1:0] act_src;
  logic [DIV_W-1:0] cnt;
  logic             tick;
  logic             idle;
  logic             at_last;
  logic [DIV_W:0]   hi_len;

  assign tick    = src_en[act_src];
  assign idle    = (act_div == '0);
  assign at_last = (cnt == DIV_W'(last_count(int'(act_div))));
  assign wrap    = idle || (tick && at_last);
  assign hi_len  = (DIV_W+1)'(high_len(int'(act_div)));
  assign clk_out = !idle && ({1'b0, cnt} < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      act_src <= '0;
      cnt     <= '0;
    end else if (wrap) begin
      act_div <= nxt_div;
      act_src <= nxt_src;
      cnt     <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: settings never change in the middle of a period
  a_r6_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_div) && $stable(act_src)));

  // R6: between loads the output only moves on a selected strobe
  a_r6_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick || wrap) |=> $stable(clk_out));

  // R5: counter stays inside the period
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (cnt < act_div));

  // R7: an idle channel picks up the offered divisor on the next clock
  a_r7_idle_reload: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (act_div == $past(nxt_div)));

endmodule

// File: rtl/clk_postdiv_pair.sv
module clk_postdiv_pair
  import postdiv_pkg::*;
#(
  parameter int N_SRC  = N_SRC_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int SEL_W  = SEL_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_a,
  output logic              out_b
);

  localparam int N_CH  = 2;
  localparam int SRC_W = $clog2(N_SRC);

  logic [N_CH-1:0][DIV_W-1:0] nxt_div;
  logic [N_CH-1:0][SRC_W-1:0] nxt_src;
  logic                       bank;
  logic [N_CH-1:0]            ch_out;
  logic [N_CH-1:0]            ch_wrap;

  postdiv_regs #(
    .N_CH(N_CH), .N_SRC(N_SRC), .DIV_W(DIV_W),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel     (sel),
    .nxt_div (nxt_div),
    .nxt_src (nxt_src),
    .bank    (bank)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    postdiv_channel #(
      .N_SRC(N_SRC), .DIV_W(DIV_W)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_en  (src_en),
      .nxt_div (nxt_div[ch]),
      .nxt_src (nxt_src[ch]),
      .clk_out (ch_out[ch]),
      .wrap    (ch_wrap[ch])
    );
  end

  assign out_a = ch_out[0];
  assign out_b = ch_out[1];

  // R1: both outputs low in the first cycle out of reset
  a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_a && !out_b));

endmodule

// File: tb/tb_clk_postdiv_pair.sv
module tb_clk_postdiv_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_en = '0;
  logic [2:0] sel = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       out_a;
  logic       out_b;

  always #5 clk = ~clk;

  clk_postdiv_pair dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .sel(sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_a(out_a), .out_b(out_b)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int r_div [2][2];
  int r_xbar = 0;
  int r_map  = 0;
  int m_div [2];
  int m_src [2];
  int m_cnt [2];

  function automatic bit m_out(int ch);
    return (m_div[ch] != 0) && (m_cnt[ch] < (m_div[ch] + 1) / 2);
  endfunction

  task automatic model_step();
    for (int ch = 0; ch < 2; ch++) begin
      bit t;
      t = src_en[m_src[ch]];
      if (m_div[ch] == 0 || (t && m_cnt[ch] == m_div[ch] - 1)) begin
        int b;
        b = (r_map >> sel) & 1;
        m_div[ch] = r_div[ch][b];
        m_src[ch] = (r_xbar >> (2 * ch)) & 3;
        m_cnt[ch] = 0;
      end else if (t) begin
        m_cnt[ch]++;
      end
    end
    if (wr_en) begin
      if (wr_addr < 4) r_div[wr_addr / 2][wr_addr % 2] = wr_data & 127;
      else if (wr_addr == 4) r_xbar = wr_data;
      else if (wr_addr == 5) r_map = wr_data;
    end
  endtask

  task automatic compare();
    n_vec++;
    if (out_a !== m_out(0) || out_b !== m_out(1)) begin
      n_bad++;
      $display("FAIL %s: out_a=%0b out_b=%0b expected %0b %0b at %0t",
               cur_req, out_a, out_b, m_out(0), m_out(1), $time);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    model_step();
    compare();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      if (mode == 0) src_en = 4'hF;
      else src_en = 4'($urandom);
      cycle();
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_div[c] = 0; m_src[c] = 0; m_cnt[c] = 0;
      r_div[c][0] = 0; r_div[c][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, outputs low with strobes running
    cur_req = "R1";
    compare();
    run(8, 1);

    // R3 / R5: bank 0 divisors, reference strobe always on
    cur_req = "R5";
    wr(0, 3); wr(2, 4);
    run(30, 0);
    wr(0, 6); wr(2, 5);
    run(40, 0);

    // R2: route A to synth 1 and B to synth 3 with sparse strobes
    cur_req = "R2";
    wr(4, 8'b11_01);
    run(120, 1);

    // R4 / R6: bank 1 values, map pattern, sel toggled mid-period
    cur_req = "R4";
    wr(1, 7); wr(3, 2); wr(5, 8'b1010_0101);
    for (int k = 0; k < 24; k++) begin
      sel = 3'(k);
      run(9, 1);
    end

    // R8: writes to unused addresses change nothing
    cur_req = "R8";
    for (int a = 6; a < 16; a++) begin
      wr(a, 8'($urandom));
      run(5, 1);
    end
    run(60, 1);

    // R7: zero divisor holds low, then recovers
    cur_req = "R7";
    wr(5, 0); sel = 0; wr(4, 0);
    wr(0, 0); wr(2, 0);
    run(40, 0);
    wr(0, 5);
    run(30, 0);

    // R9: divide by one stays high; R5: largest divisor
    cur_req = "R9";
    wr(0, 1); wr(2, 127);
    run(300, 0);

    // R6: random writes and select changes
    cur_req = "R6";
    for (int k = 0; k < 3000; k++) begin
      src_en = 4'($urandom);
      if ($urandom % 16 == 0) sel = 3'($urandom);
      if ($urandom % 40 == 0) begin
        wr_en = 1'b1;
        wr_addr = 4'($urandom % 6);
        wr_data = 8'($urandom % 12);
      end
      cycle();
      wr_en = 1'b0;
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule